// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a 256-byte, byte-wide nonvolatile store that sits on a two-wire serial bus. A fast system clock samples the bus clock and data lines. The block pulls the data line low through an open-drain enable and never drives it high. It recognises start and stop conditions, compares the three address bits in the device address byte with three strap inputs, and runs the write and read protocols. Writes are single bytes or pages of up to eight bytes. Reads are current-address, random (a dummy write that loads the address, then a read) and sequential.

Data bytes of a write are collected in a page buffer. The stop condition commits them to a register array and starts a simulated self-timed write cycle. For that cycle, whose length is a parameter counted in system clocks, the target ignores the bus entirely, so a host can poll with the device address until it is acknowledged. A write-protect input, sampled at the stop, keeps the array unchanged. The bus is a plain bit-level protocol, so the block has no valid/ready stream at its edge; every pin is a plain level.

Top module: `eeprom_twi_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends the transfer. A write whose stop arrives after the word address and before any data byte leaves the array unchanged and starts no write cycle, but it loads the address counter with that word address.
- R2: The device address byte is received MSB first as 1010, then three address bits, then a read/write bit (1 = read, 0 = write). When it matches, the target pulls SDA low during the ninth SCL pulse and releases it at the following SCL fall.
- R3: If the upper four bits are not 1010, or the three address bits differ from `strap_id`, the target does not acknowledge. It leaves SDA released until the next start.
- R4: In a write, the byte after the device address is the word address and later bytes are data. Every one of them is acknowledged. The stop commits the data to the array.
- R5: After each data byte only the low three address bits increment, so writes wrap inside their 8-byte page. A ninth or later byte overwrites the one written earlier at the same slot.
- R6: A stop that commits at least one data byte starts a busy period of `WRITE_CYCLES` clocks. During it the target acknowledges nothing, including its own address. After it ends the target acknowledges again.
- R7: While `wr_protect` is 1 at the stop, data bytes are still acknowledged, but the array is not changed and no busy period starts.
- R8: The address counter holds the last accessed address plus one. A read started directly returns the byte at that address.
- R9: A write that carries only a word address, followed by a repeated start with a read, returns the byte at that word address.
- R10: A read continues with the next address for as long as the host acknowledges, and the address wraps from 255 to 0. A host no-acknowledge ends the read, and the target leaves SDA released.
- R11: A repeated start during a write discards the data bytes buffered so far, with no commit and no busy period. The address counter keeps its advanced value.
- R12: After reset SDA is released, the address counter is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_id | input | 3 | Hard-wired address bits compared with the device address byte |
| wr_protect | input | 1 | 1 blocks commits to the array |

## Verification
Two things can fall in the same cycle here: the host's acknowledge-polling start and the end of the internal write timer. Right after each committing stop, the bench polls the device address back to back. It records the cycle of every start it issues. It requires at least one refused poll, and it requires that the first acknowledged start comes no earlier than `WRITE_CYCLES` clocks after the stop and within one poll length of it. The same polling shows that protected writes, writes with no data and writes cut off by a repeated start start no timer at all.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_DATA,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         BYTE_W     = 8;

endpackage

// File: rtl/twi_ee_linesync.sv
module twi_ee_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_ff[STAGES-1];
  assign sda_lvl = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = ~scl_q & scl_lvl;
  assign scl_fall  = scl_q & ~scl_lvl;
  assign start_det = scl_q & scl_lvl & sda_q & ~sda_lvl;
  assign stop_det  = scl_q & scl_lvl & ~sda_q & sda_lvl;

endmodule

// File: rtl/twi_ee_pagebuf.sv
module twi_ee_pagebuf #(
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr,
  input  logic [PAGE_W-1:0]           slot,
  input  logic [DW-1:0]               din,
  output logic [(1<<PAGE_W)*DW-1:0]   dout,
  output logic [(1<<PAGE_W)-1:0]      mask
);

  localparam int PAGE = 1 << PAGE_W;

  for (genvar s = 0; s < PAGE; s++) begin : g_slot
    logic [DW-1:0] byte_q;
    logic          full_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        full_q <= 1'b0;
      end else if (clr) begin
        full_q <= 1'b0;
      end else if (wr && slot == PAGE_W'(s)) begin
        byte_q <= din;
        full_q <= 1'b1;
      end
    end

    assign dout[s*DW +: DW] = byte_q;
    assign mask[s]          = full_q;
  end

endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array #(
  parameter int AW     = 8,
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               rd_addr,
  output logic [DW-1:0]               rd_data,
  input  logic                        cm_en,
  input  logic [AW-PAGE_W-1:0]        cm_page,
  input  logic [(1<<PAGE_W)*DW-1:0]   cm_data,
  input  logic [(1<<PAGE_W)-1:0]      cm_mask
);

  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PGW   = AW - PAGE_W;

  logic [DEPTH*DW-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam int             SLOT   = g % PAGE;
    localparam logic [PGW-1:0] PG_IDX = PGW'(g / PAGE);
    logic [DW-1:0] cell_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (cm_en && cm_page == PG_IDX && cm_mask[SLOT]) begin
        cell_q <= cm_data[SLOT*DW +: DW];
      end
    end

    assign cells[g*DW +: DW] = cell_q;
  end

  assign rd_data = cells[rd_addr*DW +: DW];

endmodule

// File: rtl/twi_ee_wtimer.sv
module twi_ee_wtimer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kick) begin
      cnt_q <= CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/eeprom_twi_target.sv
module eeprom_twi_target
  import twi_ee_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_id,
  input  logic       wr_protect
);

  localparam int PAGE = 1 << PAGE_W;
  localparam int PGW  = ADDR_W - PAGE_W;

  // line conditioning
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_ee_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // protocol state
  twi_state_e             state_q;
  logic [3:0]             bit_cnt;
  logic [BYTE_W-1:0]      rx_sh;
  logic [BYTE_W-2:0]      tx_sh;
  logic [ADDR_W-1:0]      addr_q;
  logic                   rd_mode;
  logic                   wr_xfer;
  logic                   host_ack;
  logic                   sda_oe_q;
  logic                   busy;
  logic                   st_idle;

  // storage side
  logic [BYTE_W-1:0]      rd_data;
  logic                   pb_clr, pb_wr, commit;
  logic [PAGE*BYTE_W-1:0] pb_data;
  logic [PAGE-1:0]        pb_mask;
  logic                   rx_done, dev_match;

  assign st_idle   = (state_q == ST_IDLE);
  assign rx_done   = scl_fall && (bit_cnt == 4'd8);
  assign dev_match = (rx_sh[7:4] == DEV_PREFIX) && (rx_sh[3:1] == strap_id);

  assign pb_clr = ~busy & (start_det | stop_det);
  assign pb_wr  = ~busy & ~start_det & ~stop_det & (state_q == ST_DATA) & rx_done;
  assign commit = ~busy & stop_det & wr_xfer & (|pb_mask) & ~wr_protect;

  twi_ee_pagebuf #(.PAGE_W(PAGE_W), .DW(BYTE_W)) u_pagebuf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pb_clr),
    .wr    (pb_wr),
    .slot  (addr_q[PAGE_W-1:0]),
    .din   (rx_sh),
    .dout  (pb_data),
    .mask  (pb_mask)
  );

  twi_ee_array #(.AW(ADDR_W), .PAGE_W(PAGE_W), .DW(BYTE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_data (rd_data),
    .cm_en   (commit),
    .cm_page (addr_q[ADDR_W-1:PAGE_W]),
    .cm_data (pb_data),
    .cm_mask (pb_mask)
  );

  twi_ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (commit),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      addr_q   <= '0;
      rd_mode  <= 1'b0;
      wr_xfer  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (busy) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
      wr_xfer  <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_DEV;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
      wr_xfer  <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
      wr_xfer  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WORD, ST_DATA: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (rx_done) begin
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                sda_oe_q <= 1'b1;
                rd_mode  <= rx_sh[0];
                wr_xfer  <= ~rx_sh[0];
                state_q  <= ST_DEV_ACK;
              end else begin
                state_q  <= ST_IDLE;
              end
            end else begin
              if (state_q == ST_WORD) begin
                addr_q <= rx_sh;
              end else begin
                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
              end
              sda_oe_q <= 1'b1;
              state_q  <= ST_RX_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh    <= rd_data[BYTE_W-2:0];
              sda_oe_q <= ~rd_data[BYTE_W-1];
              addr_q   <= addr_q + ADDR_W'(1);
              state_q  <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_WORD;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            bit_cnt  <= '0;
            state_q  <= ST_DATA;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe_q <= 1'b0;
              host_ack <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              sda_oe_q <= ~tx_sh[BYTE_W-2];
              tx_sh    <= {tx_sh[BYTE_W-3:0], 1'b0};
              bit_cnt  <= bit_cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (host_ack) begin
              tx_sh    <= rd_data[BYTE_W-2:0];
              sda_oe_q <= ~rd_data[BYTE_W-1];
              addr_q   <= addr_q + ADDR_W'(1);
              state_q  <= ST_TX;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

endmodule

// File: rtl/twi_ee_checks.sv
module twi_ee_checks #(
  parameter int PGW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sda_oe,
  input logic           scl_fall,
  input logic           stop_det,
  input logic           busy,
  input logic           st_idle,
  input logic           wr_protect,
  input logic           pb_wr,
  input logic [PGW-1:0] addr_page
);

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));                                  // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);                                                // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st_idle && !sda_oe));                                      // R6
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));                                    // R6
  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_protect));                                 // R7
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr |=> $stable(addr_page));                                       // R5

endmodule

bind eeprom_twi_target twi_ee_checks #(.PGW(ADDR_W - PAGE_W)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe),
  .scl_fall   (scl_fall),
  .stop_det   (stop_det),
  .busy       (busy),
  .st_idle    (st_idle),
  .wr_protect (wr_protect),
  .pb_wr      (pb_wr),
  .addr_page  (addr_q[ADDR_W-1:PAGE_W])
);

// File: tb/test_eeprom_twi_target.sv
module test_eeprom_twi_target;

  localparam int         CLK_PERIOD = 10;
  localparam int         WCYC       = 300;
  localparam int         Q          = 4;
  localparam logic [2:0] STRAP      = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       host_oe = 1'b0;
  logic       wp = 1'b0;
  logic       dut_oe;
  logic       sda_line;

  assign sda_line = ~(host_oe | dut_oe);

  eeprom_twi_target #(.WRITE_CYCLES(WCYC)) i_eeprom_twi_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe     (dut_oe),
    .strap_id   (STRAP),
    .wr_protect (wp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int start_cyc = 0;
  int stop_cyc  = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [16];
  logic [7:0] cur;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_oe = 1'b0; idle(Q);
    scl = 1'b1;     idle(2*Q);
    host_oe = 1'b1; start_cyc = cyc; idle(2*Q);
    scl = 1'b0;     idle(Q);
  endtask

  task automatic bus_stop();
    host_oe = 1'b1; idle(Q);
    scl = 1'b1;     idle(2*Q);
    host_oe = 1'b0; stop_cyc = cyc; idle(4*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_oe = ~b[i]; idle(Q);
      scl = 1'b1;      idle(2*Q);
      scl = 1'b0;      idle(Q);
    end
    host_oe = 1'b0; idle(Q);
    scl = 1'b1;     idle(Q);
    ack = ~sda_line; idle(Q);
    scl = 1'b0;     idle(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      idle(Q); scl = 1'b1;
      idle(Q); b[i] = sda_line;
      idle(Q); scl = 1'b0;
      idle(Q);
    end
    host_oe = give_ack; idle(Q);
    scl = 1'b1;         idle(2*Q);
    scl = 1'b0;         idle(Q);
    host_oe = 1'b0;     idle(Q);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] id, input logic rd);
    return {4'b1010, id, rd};
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 5) ^ 'h3C);
  endfunction

  // write n data bytes from wbuf starting at word address a
  task automatic wr_seq(input logic [7:0] a, input int n, input string tag);
    logic ack;
    logic [2:0] slot;
    bus_start();
    send_byte(dev_byte(STRAP, 1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte(a, ack);                     chk(ack, "R4 word ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      chk(ack, tag, ack, 1);
      slot = 3'(a[2:0] + 3'(k));
      if (!wp) model[{a[7:3], slot}] = wbuf[k];
    end
    bus_stop();
    cur = {a[7:3], 3'(a[2:0] + 3'(n))};
  endtask

  task automatic rd_body(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(b, (k < n - 1));
      chk(b == model[cur], tag, b, model[cur]);
      cur = cur + 8'd1;
    end
    chk(dut_oe == 1'b0, "R10 released after nack", dut_oe, 0);
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(dev_byte(STRAP, 1'b1), ack); chk(ack, "R8 read dev ack", ack, 1);
    rd_body(n, tag);
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(dev_byte(STRAP, 1'b0), ack); chk(ack, "R9 dummy dev ack", ack, 1);
    send_byte(a, ack);                     chk(ack, "R9 dummy word ack", ack, 1);
    bus_start();
    send_byte(dev_byte(STRAP, 1'b1), ack); chk(ack, "R9 read dev ack", ack, 1);
    cur = a;
    rd_body(n, tag);
  endtask

  task automatic poll(output int nacks, output int elapsed);
    logic ack;
    int c0;
    int ref_stop;
    ref_stop = stop_cyc;
    nacks = 0;
    c0 = 0;
    for (int t = 0; t < 40; t++) begin
      bus_start();
      c0 = start_cyc;
      send_byte(dev_byte(STRAP, 1'b0), ack);
      bus_stop();
      if (ack) break;
      nacks++;
    end
    elapsed = c0 - ref_stop;
  endtask

  task automatic check_busy(input string tag);
    int nk, el;
    poll(nk, el);
    chk(nk >= 1, tag, nk, 1);
    chk(el >= WCYC && el <= WCYC + 260, tag, el, WCYC);
  endtask

  task automatic check_not_busy(input string tag);
    int nk, el;
    poll(nk, el);
    chk(nk == 0, tag, nk, 0);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    cur = 8'h00;

    // R12: reset state
    idle(5);
    chk(dut_oe == 1'b0, "R12 line released in reset", dut_oe, 0);
    rst_n = 1'b1;
    idle(10);
    chk(dut_oe == 1'b0, "R12 line released after reset", dut_oe, 0);
    rd_cur(4, "R12 reset contents from counter 0");

    // R4/R6/R9: byte write, busy window, random read back
    wbuf[0] = 8'hA7;
    wr_seq(8'h25, 1, "R4 data ack");
    check_busy("R6 busy window after byte write");
    rd_rand(8'h25, 1, "R9 random read of written byte");

    // R1: stop after word address only: no cycle, counter loaded
    wr_seq(8'h25, 0, "R1 no data");
    check_not_busy("R1 no write cycle without data");
    rd_cur(1, "R1 counter loaded by word address");

    // R5/R8: page write wrapping inside the page
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(k * 17 + 3);
    wr_seq(8'h3D, 10, "R5 page data ack");
    check_busy("R6 busy window after page write");
    rd_cur(1, "R8 current address after page write");
    rd_rand(8'h38, 8, "R5 page contents after wrap");

    // R2/R3: address sweep against the straps
    for (int v = 0; v < 8; v++) begin
      bus_start();
      send_byte(dev_byte(3'(v), 1'b0), ack);
      chk(ack == (3'(v) == STRAP), (3'(v) == STRAP) ? "R2 strap match ack" : "R3 strap mismatch nack",
          ack, (3'(v) == STRAP));
      if (!ack) begin
        send_byte(8'h00, ack);
        chk(!ack, "R3 silent after mismatch", ack, 0);
      end
      bus_stop();
    end
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack);
    chk(!ack, "R3 wrong prefix nack", ack, 0);
    bus_stop();

    // R7: write protect
    wbuf[0] = 8'h5A;
    wr_seq(8'h10, 1, "R4 data ack");
    check_busy("R6 busy before protect test");
    wp = 1'b1;
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    wr_seq(8'h10, 2, "R7 protected data still acked");
    check_not_busy("R7 no write cycle when protected");
    wp = 1'b0;
    rd_rand(8'h10, 2, "R7 protected bytes unchanged");

    // R11: repeated start inside a write discards the data
    bus_start();
    send_byte(dev_byte(STRAP, 1'b0), ack); chk(ack, "R11 dev ack", ack, 1);
    send_byte(8'h40, ack);                 chk(ack, "R11 word ack", ack, 1);
    send_byte(8'h99, ack);                 chk(ack, "R11 data ack", ack, 1);
    cur = 8'h41;
    bus_start();
    send_byte(dev_byte(STRAP, 1'b1), ack); chk(ack, "R11 read after restart", ack, 1);
    rd_body(1, "R11 counter advanced past discarded byte");
    check_not_busy("R11 no write cycle after restart");
    rd_rand(8'h40, 1, "R11 discarded byte not stored");

    // R10: fill the whole array, then one long sequential read with wrap
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = pat(p * 8 + k);
      wr_seq(8'(p * 8), 8, "R4 fill data ack");
      check_busy("R6 busy window during fill");
    end
    rd_rand(8'hF8, 264, "R10 sequential read across wrap");
    rd_cur(2, "R8 counter after wrapped read");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule